// File: doc/BRIEF.md
# Receive Character Queue with Error Tagging

This block buffers characters coming out of an asynchronous serial receiver. Each stored entry pairs the received byte with a status byte that records a break, a parity error, a framing error, a lost-character (overrun) mark and a three-bit special-character match code. A host services the queue in service cycles. It may strobe a status read and/or a data read, which copy the head entry's status or data byte into a registered read port. It closes each cycle with an end-of-service strobe, which normally removes the head entry whether or not it was read.

Behind the ring of `DEPTH` entries sits one holding register, so the block stores `DEPTH+1` characters. A character that arrives when both are occupied is thrown away. The overrun mark is then placed on the newest entry already stored, so that entry's data is still good. An entry that carries the overrun mark is only removed when its status has been read in the same service cycle. This stops the loss report from being discarded unseen.

An idle timer counts bit-clock ticks. Once a removal has happened, the timer raises a timeout flag if no character arrives within the programmed number of ticks and reporting is enabled.

Top module: `rx_exc_fifo`

## Requirements
- R1: After a synchronous active-low reset, `req_nempty`, `tmo_flag` and `rd_port` are all 0 and the queue is empty.
- R2: Entries leave in arrival order. The status byte layout is: bit 7 = 0, bits 6:4 = special-character code, bit 3 = break, bit 2 = parity error, bit 1 = framing error, bit 0 = overrun.
- R3: A `rd_status` strobe loads the head status byte into `rd_port` on the next clock edge, and a `rd_data` strobe loads the head data byte. If both are strobed in the same cycle, the status byte wins.
- R4: An `ack_end` strobe removes the head entry when nothing was read, and also when only the status was read, provided the head carries no overrun mark.
- R5: The block holds at most `DEPTH+1` entries. A character arriving when it is full, with no removal in that cycle, is dropped, and bit 0 is set on the most recently stored entry.
- R6: A head entry with bit 0 set is not removed by `ack_end` unless `rd_status` was strobed since the previous `ack_end` or in the same cycle.
- R7: `req_nempty` is 1 exactly when an entry is stored. It drops combinationally in the cycle in which `ack_end` consumes the last entry.
- R8: A character arriving in the same cycle as a removal from a full queue is stored, and no overrun mark is set.
- R9: The idle timer reloads to `tmo_period` on every arrival and every removal, and counts down on each `bit_tick`. `tmo_flag` is 1 when `tmo_en` is 1, at least one removal has happened since reset, and the count has reached 0.
- R10: `ack_end` while the queue is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A received character is present this cycle |
| in_data | input | 8 | Received character |
| in_brk | input | 1 | Break detected with this character |
| in_par_err | input | 1 | Parity error on this character |
| in_frm_err | input | 1 | Bad stop bit on this character |
| in_spc | input | 3 | Special-character match code |
| rd_status | input | 1 | Status read strobe |
| rd_data | input | 1 | Data read strobe |
| ack_end | input | 1 | End of service cycle strobe |
| bit_tick | input | 1 | Bit-clock tick for the idle timer |
| tmo_en | input | 1 | Timeout reporting enable |
| tmo_period | input | TMO_W | Idle period in ticks |
| rd_port | output | 8 | Registered read port (status or data) |
| req_nempty | output | 1 | Service request: queue not empty |
| tmo_flag | output | 1 | Idle timeout indication |

## Verification
On every cycle, the assertions check the occupancy bound and the effects of reset. They also check that a full queue keeps its occupancy when a character is dropped, that an empty acknowledge leaves the queue empty, and that a removal lowers occupancy by one. Two further properties hold at all times: the service request is never raised with nothing stored, and an unread overrun head never shrinks the queue. The bench scenarios cover everything that depends on stored contents: arrival order, the status bit layout, the overrun mark moving onto the right entry, the precedence on the read port, and the same-cycle arrival and removal when full. The exact tick count at which the timeout appears is also checked there.

// File: rtl/rxq_pkg.sv
// Package: shared entry type for the receive queue.
// Assumes 8-bit characters and 8-bit status bytes.
package rxq_pkg;
    typedef struct packed {
        logic [7:0] status;
        logic [7:0] data;
    } rx_ent_t;

    localparam int OVR_BIT = 0;
endpackage

// File: rtl/rxq_ring.sv
// Module: circular storage of DEPTH entries with one push and one pop port.
// Assumes the caller never pushes when full without popping in the same cycle,
// and never pops when empty.
module rxq_ring #(
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  rxq_pkg::rx_ent_t push_ent,
    input  logic            pop,
    output rxq_pkg::rx_ent_t head,
    output logic [$clog2(DEPTH+1)-1:0] cnt
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rxq_pkg::rx_ent_t mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;

    // Advance a pointer with wrap at DEPTH-1.
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write and read pointers plus occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            if (push && !pop)      cnt <= cnt + CNT_W'(1);
            else if (pop && !push) cnt <= cnt - CNT_W'(1);
        end
    end

    // Entry storage, written at the tail.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= push_ent;
    end

    // Head entry presented to the reader.
    always_comb head = mem[rp];
endmodule

// File: rtl/rxq_hold.sv
// Module: single holding register behind the ring. It can be loaded, emptied,
// and have its overrun bit set. Load takes priority over clear; the mark is
// ignored when the register is empty.
module rxq_hold (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  rxq_pkg::rx_ent_t load_ent,
    input  logic             clear,
    input  logic             mark_ovr,
    output logic             valid,
    output rxq_pkg::rx_ent_t ent
);
    // Holding register contents and valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            ent   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            ent   <= load_ent;
        end else if (clear) begin
            valid <= 1'b0;
        end else if (mark_ovr && valid) begin
            ent.status[rxq_pkg::OVR_BIT] <= 1'b1;
        end
    end
endmodule

// File: rtl/rxq_timer.sv
// Module: idle timer. It reloads on activity, counts down on ticks, and
// flags when it is armed, enabled and expired. Arming happens on the first
// removal and lasts until reset.
module rxq_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             arm,
    input  logic             tick,
    input  logic             en,
    input  logic [TMO_W-1:0] period,
    output logic             flag
);
    logic [TMO_W-1:0] cnt;
    logic             armed;

    // Countdown register and arm latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else begin
            if (arm) armed <= 1'b1;
            if (reload)                  cnt <= period;
            else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
        end
    end

    // Timeout indication.
    always_comb flag = en && armed && (cnt == '0);
endmodule

// File: rtl/rx_exc_fifo.sv
// Module: receive queue top. It steers arrivals into the ring or the holding
// register, drops characters on overflow and marks the newest stored entry,
// pops on end of service (except for an unread overrun head), drives the
// registered read port and the idle timer.
// Assumes single-cycle strobes from the host and the receiver.
module rx_exc_fifo #(
    parameter int DEPTH = 16,
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_brk,
    input  logic             in_par_err,
    input  logic             in_frm_err,
    input  logic [2:0]       in_spc,
    input  logic             rd_status,
    input  logic             rd_data,
    input  logic             ack_end,
    input  logic             bit_tick,
    input  logic             tmo_en,
    input  logic [TMO_W-1:0] tmo_period,
    output logic [7:0]       rd_port,
    output logic             req_nempty,
    output logic             tmo_flag
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int OCC_W = $clog2(DEPTH + 2);

    rxq_pkg::rx_ent_t in_ent, head, hold_ent, ring_wr;
    logic [CNT_W-1:0] ring_cnt;
    logic [OCC_W-1:0] occ;
    logic hold_v, ring_push, hold_load, hold_clear, mark_ovr;
    logic st_seen, status_ok, head_ovr, pop, ring_room;

    // Pack the incoming character and its flags into an entry.
    always_comb begin
        in_ent.data   = in_data;
        in_ent.status = {1'b0, in_spc, in_brk, in_par_err, in_frm_err, 1'b0};
    end

    // Remember a status read within the current service cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         st_seen <= 1'b0;
        else if (ack_end)   st_seen <= 1'b0;
        else if (rd_status) st_seen <= 1'b1;
    end

    // Pop decision: an overrun head needs a status read first.
    always_comb begin
        status_ok = st_seen || rd_status;
        head_ovr  = head.status[rxq_pkg::OVR_BIT];
        pop       = ack_end && (ring_cnt != '0) && (!head_ovr || status_ok);
        ring_room = (ring_cnt != CNT_W'(DEPTH)) || pop;
    end

    // Steering of arrivals between the ring, the holding register and overflow.
    always_comb begin
        ring_push  = 1'b0;
        ring_wr    = in_ent;
        hold_load  = 1'b0;
        hold_clear = 1'b0;
        mark_ovr   = 1'b0;
        if (hold_v) begin
            if (pop) begin
                ring_push  = 1'b1;
                ring_wr    = hold_ent;
                hold_load  = in_valid;
                hold_clear = !in_valid;
            end else if (in_valid) begin
                mark_ovr = 1'b1;
            end
        end else if (in_valid) begin
            if (ring_room) ring_push = 1'b1;
            else           hold_load = 1'b1;
        end
    end

    rxq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .push(ring_push), .push_ent(ring_wr),
        .pop(pop), .head(head), .cnt(ring_cnt)
    );

    rxq_hold u_hold (
        .clk(clk), .rst_n(rst_n), .load(hold_load), .load_ent(in_ent),
        .clear(hold_clear), .mark_ovr(mark_ovr), .valid(hold_v), .ent(hold_ent)
    );

    rxq_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .reload(in_valid || pop), .arm(pop),
        .tick(bit_tick), .en(tmo_en), .period(tmo_period), .flag(tmo_flag)
    );

    // Registered read port; a status read takes precedence over a data read.
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_port <= '0;
        else if (rd_status) rd_port <= head.status;
        else if (rd_data)   rd_port <= head.data;
    end

    // Total occupancy and service request, dropping with the last pop.
    always_comb begin
        occ        = OCC_W'(ring_cnt) + OCC_W'(hold_v);
        req_nempty = (ring_cnt != '0) && !(pop && ring_cnt == CNT_W'(1) && !hold_v);
    end
endmodule

// File: rtl/rxq_checker.sv
// Module: property checker bound to the receive queue top.
module rxq_checker #(
    parameter int OCC_W = 5,
    parameter int CAP   = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             ack_end,
    input logic             rd_status,
    input logic             st_seen,
    input logic             head_ovr,
    input logic             pop,
    input logic             req_nempty,
    input logic             tmo_flag,
    input logic             tmo_en,
    input logic [OCC_W-1:0] occ
);
    a_r1_reset_empties: assert property (@(posedge clk)
        !rst_n |=> (occ == '0 && !req_nempty && !tmo_flag));

    a_r5_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(CAP));

    a_r5_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && occ == OCC_W'(CAP) && !ack_end) |=> occ == OCC_W'(CAP));

    a_r10_empty_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && ack_end && !in_valid) |=> occ == '0);

    a_r4_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !in_valid) |=> occ == $past(occ) - OCC_W'(1));

    a_r6_ovr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_end && head_ovr && req_nempty && !rd_status && !st_seen) |=> occ >= $past(occ));

    a_r7_req_implies_data: assert property (@(posedge clk) disable iff (!rst_n)
        req_nempty |-> occ != '0);

    a_r9_flag_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_flag |-> tmo_en);
endmodule

bind rx_exc_fifo rxq_checker #(.OCC_W(OCC_W), .CAP(DEPTH + 1)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ack_end(ack_end),
    .rd_status(rd_status), .st_seen(st_seen), .head_ovr(head_ovr), .pop(pop),
    .req_nempty(req_nempty), .tmo_flag(tmo_flag), .tmo_en(tmo_en), .occ(occ)
);

// File: tb/rx_exc_fifo_tb.sv
// Bench: the driver pushes expected entries into a scoreboard queue; the
// service task pops them and compares them with the read port.
module rx_exc_fifo_tb_top;
    localparam int DEPTH = 16;
    localparam int CAP   = DEPTH + 1;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_brk = 0, in_par_err = 0, in_frm_err = 0;
    logic [7:0] in_data = 0;
    logic [2:0] in_spc = 0;
    logic rd_status = 0, rd_data = 0, ack_end = 0, bit_tick = 1, tmo_en = 0;
    logic [7:0] tmo_period = 8'd5;
    logic [7:0] rd_port;
    logic req_nempty, tmo_flag;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [15:0] sb[$];

    always #4 clk = ~clk;

    rx_exc_fifo #(.DEPTH(DEPTH), .TMO_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_brk(in_brk), .in_par_err(in_par_err), .in_frm_err(in_frm_err),
        .in_spc(in_spc), .rd_status(rd_status), .rd_data(rd_data),
        .ack_end(ack_end), .bit_tick(bit_tick), .tmo_en(tmo_en),
        .tmo_period(tmo_period), .rd_port(rd_port), .req_nempty(req_nempty),
        .tmo_flag(tmo_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one character (called just after a falling edge); update the model.
    task automatic put_char(input logic [7:0] d, input bit b, input bit p,
                            input bit f, input logic [2:0] s, input bit with_ack);
        logic [7:0] st;
        st = {1'b0, s, b, p, f, 1'b0};
        in_valid = 1; in_data = d; in_brk = b; in_par_err = p;
        in_frm_err = f; in_spc = s; ack_end = with_ack;
        if (with_ack) void'(sb.pop_front());
        if (sb.size() < CAP) sb.push_back({st, d});
        else sb[sb.size()-1][8] = 1'b1;
        @(negedge clk);
        in_valid = 0; ack_end = 0;
    endtask

    // Service one entry: optional reads, then end of service, with R7 check.
    task automatic serve(input bit rs, input bit rdd, input string req);
        logic [15:0] e;
        bit consume;
        e = sb[0];
        if (rs) begin
            rd_status = 1; @(negedge clk); rd_status = 0;
            check(rd_port == e[15:8], {req, " R2 status"}, rd_port, e[15:8]);
        end
        if (rdd) begin
            rd_data = 1; @(negedge clk); rd_data = 0;
            check(rd_port == e[7:0], {req, " R2 data"}, rd_port, e[7:0]);
        end
        consume = !(e[8] && !rs);
        ack_end = 1;
        #1;
        check(req_nempty == !(consume && sb.size() == 1), "R7 req in ack cycle",
              req_nempty, !(consume && sb.size() == 1));
        @(negedge clk);
        ack_end = 0;
        if (consume) void'(sb.pop_front());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_nempty == 0, "R1 req after reset", req_nempty, 0);
        check(rd_port == 0, "R1 rd_port after reset", rd_port, 0);
        check(tmo_flag == 0, "R1 tmo after reset", tmo_flag, 0);
        rst_n = 1;
        tmo_en = 1;
        repeat (10) @(negedge clk);
        check(tmo_flag == 0, "R9 no timeout before first removal", tmo_flag, 0);

        // R2: order and status layout
        put_char(8'h41, 1, 0, 0, 3'd0, 0);
        put_char(8'h42, 0, 1, 1, 3'd5, 0);
        put_char(8'h43, 0, 0, 0, 3'd7, 0);
        check(req_nempty == 1, "R7 req with data", req_nempty, 1);
        repeat (3) serve(1, 1, "R2");

        // R3: status wins over data
        put_char(8'h5A, 0, 1, 0, 3'd2, 0);
        rd_status = 1; rd_data = 1; @(negedge clk); rd_status = 0; rd_data = 0;
        check(rd_port == sb[0][15:8], "R3 status priority", rd_port, sb[0][15:8]);
        serve(0, 1, "R3");

        // R4: unread and status-only consumption
        put_char(8'h10, 0, 0, 0, 3'd0, 0);
        put_char(8'h11, 0, 0, 1, 3'd0, 0);
        put_char(8'h12, 0, 0, 0, 3'd1, 0);
        serve(0, 0, "R4 unread");
        serve(1, 0, "R4 status only");
        serve(1, 1, "R4 next is third");

        // R5: overflow drops and marks newest stored entry
        for (int i = 0; i < CAP + 1; i++) put_char(8'(8'h80 + i), 0, 0, 0, 3'd0, 0);
        check(sb[CAP-1][8] == 1, "R5 model mark", sb[CAP-1][8], 1);
        for (int i = 0; i < CAP; i++) serve(1, 1, "R5");
        check(req_nempty == 0, "R5 drained", req_nempty, 0);

        // R6: unread overrun head is kept
        for (int i = 0; i < CAP + 1; i++) put_char(8'(8'hC0 + i), 0, 0, 0, 3'd4, 0);
        for (int i = 0; i < CAP - 1; i++) serve(0, 0, "R6 drain");
        serve(0, 0, "R6 blocked ack");
        check(req_nempty == 1, "R6 overrun head kept", req_nempty, 1);
        check(sb.size() == 1, "R6 model", sb.size(), 1);
        serve(1, 1, "R6 read then consume");
        check(req_nempty == 0, "R6 empty after", req_nempty, 0);

        // R8: arrival with removal on a full queue
        for (int i = 0; i < CAP; i++) put_char(8'(8'h20 + i), 0, 0, 0, 3'd3, 0);
        put_char(8'h77, 1, 1, 0, 3'd6, 1);
        for (int i = 0; i < CAP; i++) begin
            check(sb[0][8] == 0, "R8 no overrun mark", sb[0][8], 0);
            serve(1, 1, "R8");
        end

        // R10: ack on empty
        ack_end = 1; @(negedge clk); ack_end = 0;
        check(req_nempty == 0, "R10 empty ack", req_nempty, 0);
        put_char(8'h99, 0, 0, 1, 3'd1, 0);
        serve(1, 1, "R10 after empty ack");

        // R9: timeout after removal, counted in ticks
        repeat (4) @(negedge clk);
        check(tmo_flag == 0, "R9 before period", tmo_flag, 0);
        @(negedge clk);
        check(tmo_flag == 1, "R9 at period", tmo_flag, 1);
        put_char(8'h01, 0, 0, 0, 3'd0, 0);
        check(tmo_flag == 0, "R9 arrival reloads", tmo_flag, 0);
        serve(1, 1, "R9");
        repeat (6) @(negedge clk);
        tmo_en = 0; #1;
        check(tmo_flag == 0, "R9 disabled", tmo_flag, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule